// File: doc/BRIEF.md
# Paged-Write Serial Bus Target with Acknowledge Polling

This block is a two-wire serial bus (I2C) target. A fast system clock samples the bus clock and data lines, filters out narrow glitches on both, and finds START, repeated START and STOP conditions. The target answers to one 7-bit device address. The upper six bits are a parameter, and a strap input supplies the lowest bit. The default parameter gives the address bytes C0h for a write and C1h for a read when the strap is low. The block turns bus transfers into one-cycle write and read requests toward a byte-wide register store.

In a write transfer, the byte after the address byte loads an internal 8-bit location counter. Each data byte after that is presented to the store and then advances the counter, but only the three low bits advance. As a result, a long burst wraps around inside its own aligned 8-byte row. In a read transfer, bytes are fetched from the counter's current value, and the counter then advances over the full 8-bit range. A read therefore continues from wherever the last transfer left the counter. A write that carries only the location byte, followed by a repeated START, sets where the read begins. While the store reports that a slow commit is in progress, the target refuses its own address with a NACK. The host can therefore poll the device until it acknowledges again.

The controller is one state machine. Its states are:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: driving the address acknowledge.
- `ST_REG`: shifting in the location byte.
- `ST_REG_ACK`: driving the acknowledge for the location byte.
- `ST_WDATA`: shifting in a data byte.
- `ST_WDATA_ACK`: driving the acknowledge for a data byte.
- `ST_RDATA`: shifting out a data byte.
- `ST_RD_ACK`: sampling the host's acknowledge.
- `ST_IGNORE`: not addressed.

Two transitions apply from every state: START goes to `ST_ADDR`, and STOP goes to `ST_IDLE`. The address byte is complete on the falling clock edge after its eighth bit. If it matches and the store is not busy, the machine goes to `ST_ADDR_ACK`; otherwise it goes to `ST_IGNORE`. Every other transition happens on a falling bus-clock edge, as follows:
- `ST_ADDR_ACK` goes to `ST_RDATA` for a read, or to `ST_REG` for a write.
- `ST_REG` goes to `ST_REG_ACK`, and `ST_REG_ACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RDATA` if the host acknowledged, or to `ST_IGNORE` if it did not.

Top module: `i2c_row_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 110000 followed by `addr_strap`. The eighth bit selects the direction: 0 is write and 1 is read. To acknowledge, the target drives SDA low (`sda_oe` = 1) for the whole ninth bit.
- R2: After an address byte that does not match, the target drives nothing and issues no store request until the next START, and it leaves the location counter unchanged.
- R3: In a write transfer, the first byte after the address byte loads the location counter. That byte produces no store write.
- R4: Each later write byte goes to the counter's location. The counter's low three bits then advance modulo 8 while bits 7..3 are held, so a burst stays inside its aligned 8-byte row.
- R5: A read begins at the current counter value. A location byte followed by a repeated START sets that value.
- R6: Each byte read advances the counter modulo 256, so FFh is followed by 00h. A host ACK (SDA low in the ninth bit) continues the read. A NACK ends it, and the target stops driving SDA.
- R7: While `store_busy` is high at the end of the address byte, the target does not acknowledge. It then ignores the transfer and issues no store request.
- R8: A START anywhere, including inside a transfer, begins a new address phase. A STOP returns the target to idle. Both release SDA.
- R9: A pulse on SDA or SCL that lasts one system clock is ignored. For example, a one-cycle low pulse on SDA while SCL is high creates neither a START nor a STOP.
- R10: After reset, `sda_oe`, `wr_req` and `rd_req` are low.
- R11: Each acknowledged data byte of a write produces exactly one single-cycle `wr_req`, carrying its location and value. Bytes are transferred MSB first, and SDA is sampled on the rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Lowest bit of the device address |
| store_busy | input | 1 | Store is committing; refuse the address |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_req | output | 1 | One-cycle store write strobe |
| wr_addr | output | 8 | Store write location |
| wr_data | output | 8 | Store write value |
| rd_req | output | 1 | One-cycle store read strobe |
| rd_addr | output | 8 | Store read location |
| rd_data | input | 8 | Store read value, valid the cycle after `rd_req` |

## Verification
The bench targets the following corner cases:
- A burst that starts at offset 6 of a row. A target that carried into bit 3 would write into the next row.
- A read that crosses FFh. A counter that wrapped by rows would return FFh's row start instead of 00h.
- Acknowledge polling under `store_busy`, and a mismatched address followed by data bytes. A faulty target would acknowledge or write, or would leave a moved counter that a later bare read exposes.
- A repeated START in the middle of a write, and a one-cycle SDA pulse during a clock-high data bit. A faulty target would lose the second transfer, or would turn the pulse into a spurious restart and corrupt the stored bytes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int ONES_W = $clog2(TAPS + 1);
    localparam int HALF   = TAPS / 2;

    logic [1:0]        sync_q;
    logic [TAPS-1:0]   win_q;
    logic [ONES_W-1:0] ones;
    logic              dout_q;

    always_comb begin
        ones = '0;
        for (int i = 0; i < TAPS; i++) begin
            ones = ones + ONES_W'(win_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            dout_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            win_q  <= {win_q[TAPS-2:0], sync_q[1]};
            dout_q <= (ones > ONES_W'(HALF));
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev_rise  = scl_f & ~scl_q;
        ev_fall  = ~scl_f & scl_q;
        ev_start = scl_f & scl_q & sda_q & ~sda_f;
        ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int         ROW_BITS = 3,
    parameter logic [5:0] DEV_HI   = 6'b110000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              sda_s,
    input  logic              addr_strap,
    input  logic              store_busy,
    output logic              sda_oe,
    output logic              wr_req,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req,
    output logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int ROW_HI = BYTE_W - ROW_BITS;

    tgt_state_e state_q, state_d;

    logic [BYTE_W-1:0] sh_q;
    logic [2:0]        cnt_q;
    logic              got8_q;
    logic              rw_q;
    logic [BYTE_W-1:0] ptr_q;
    logic [BYTE_W-2:0] tx_q;
    logic [BYTE_W-1:0] txbuf_q;
    logic              fetch_q;
    logic              mack_q;
    logic              oe_q;
    logic              wr_req_q;
    logic [BYTE_W-1:0] wr_addr_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic              rd_req_q;
    logic [BYTE_W-1:0] rd_addr_q;

    logic addr_hit;
    logic byte_end;
    logic counting;

    function automatic logic [BYTE_W-1:0] row_inc(input logic [BYTE_W-1:0] a);
        row_inc = {a[BYTE_W-1:ROW_BITS], a[ROW_BITS-1:0] + 1'b1};
    endfunction

    assign addr_hit = (sh_q[BYTE_W-1:1] == {DEV_HI, addr_strap});
    assign byte_end = ev_fall && got8_q;
    assign counting = (state_q == ST_ADDR) || (state_q == ST_REG) ||
                      (state_q == ST_WDATA) || (state_q == ST_RDATA);

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (ev_start) begin
            state_d = ST_ADDR;
        end else if (ev_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_IGNORE:    state_d = ST_IGNORE;
                ST_ADDR:      if (byte_end)
                                  state_d = (addr_hit && !store_busy) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (ev_fall) state_d = rw_q ? ST_RDATA : ST_REG;
                ST_REG:       if (byte_end) state_d = ST_REG_ACK;
                ST_REG_ACK:   if (ev_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_end) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ev_fall) state_d = ST_WDATA;
                ST_RDATA:     if (byte_end) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (ev_fall) state_d = mack_q ? ST_RDATA : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            cnt_q     <= '0;
            got8_q    <= 1'b0;
            rw_q      <= 1'b0;
            ptr_q     <= '0;
            tx_q      <= '0;
            txbuf_q   <= '0;
            fetch_q   <= 1'b0;
            mack_q    <= 1'b0;
            oe_q      <= 1'b0;
            wr_req_q  <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            rd_req_q  <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            wr_req_q <= 1'b0;
            rd_req_q <= 1'b0;
            fetch_q  <= rd_req_q;
            if (fetch_q) txbuf_q <= rd_data;

            // bit counter restarts at every byte boundary
            if (ev_start || (state_d != state_q)) begin
                cnt_q  <= '0;
                got8_q <= 1'b0;
            end else if (ev_rise && counting) begin
                cnt_q  <= cnt_q + 3'd1;
                got8_q <= (cnt_q == 3'd7);
                if (state_q != ST_RDATA) sh_q <= {sh_q[BYTE_W-2:0], sda_s};
            end

            // next read bit goes out after each falling clock
            if ((state_q == ST_RDATA) && ev_fall && !got8_q && !ev_start && !ev_stop) begin
                tx_q <= {tx_q[BYTE_W-3:0], 1'b0};
                oe_q <= ~tx_q[BYTE_W-2];
            end

            // host acknowledge of a read byte
            if ((state_q == ST_RD_ACK) && ev_rise) begin
                mack_q <= ~sda_s;
                if (!sda_s) begin
                    rd_req_q  <= 1'b1;
                    rd_addr_q <= ptr_q;
                    ptr_q     <= ptr_q + 1'b1;
                end
            end

            if (ev_start || ev_stop) begin
                oe_q <= 1'b0;
            end else if (state_d != state_q) begin
                unique case (state_q)
                    ST_ADDR: if (state_d == ST_ADDR_ACK) begin
                        oe_q <= 1'b1;
                        rw_q <= sh_q[0];
                        if (sh_q[0]) begin
                            rd_req_q  <= 1'b1;
                            rd_addr_q <= ptr_q;
                            ptr_q     <= ptr_q + 1'b1;
                        end
                    end
                    ST_ADDR_ACK, ST_RD_ACK: if (state_d == ST_RDATA) begin
                        tx_q <= txbuf_q[BYTE_W-2:0];
                        oe_q <= ~txbuf_q[BYTE_W-1];
                    end else begin
                        oe_q <= 1'b0;
                    end
                    ST_REG: begin
                        ptr_q <= sh_q;
                        oe_q  <= 1'b1;
                    end
                    ST_REG_ACK, ST_WDATA_ACK, ST_RDATA: oe_q <= 1'b0;
                    ST_WDATA: begin
                        wr_req_q  <= 1'b1;
                        wr_addr_q <= ptr_q;
                        wr_data_q <= sh_q;
                        ptr_q     <= row_inc(ptr_q);
                        oe_q      <= 1'b1;
                    end
                    default: oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe  = oe_q;
    assign wr_req  = wr_req_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;
    assign rd_req  = rd_req_q;
    assign rd_addr = rd_addr_q;

    // row tracking for the write-burst check
    logic              chk_row_v;
    logic [ROW_HI-1:0] chk_row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_row_v <= 1'b0;
            chk_row_q <= '0;
        end else if (ev_start) begin
            chk_row_v <= 1'b0;
        end else if (wr_req_q) begin
            chk_row_v <= 1'b1;
            chk_row_q <= wr_addr_q[BYTE_W-1:ROW_BITS];
        end
    end

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);  // R11
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);  // R6
    AST_ROW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && chk_row_v) |-> (wr_addr[BYTE_W-1:ROW_BITS] == chk_row_q));  // R4
    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ADDR_ACK) && $rose(oe_q)) |-> !$past(store_busy));  // R7
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !sda_oe);  // R8
    AST_QUIET_UNADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IGNORE) || (state_q == ST_IDLE)) |-> (!sda_oe && !wr_req));  // R2

endmodule

// File: rtl/i2c_row_target.sv
module i2c_row_target
    import i2c_tgt_pkg::*;
#(
    parameter int         FILT_TAPS = 3,
    parameter int         ROW_BITS  = 3,
    parameter logic [5:0] DEV_HI    = 6'b110000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_strap,
    input  logic              store_busy,
    output logic              sda_oe,
    output logic              wr_req,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req,
    output logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] filt;
    logic ev_start, ev_stop, ev_rise, ev_fall;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        i2c_line_filter #(.TAPS(FILT_TAPS)) i_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (filt[g])
        );
    end

    i2c_bus_events i_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (filt[1]),
        .sda_f   (filt[0]),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall)
    );

    i2c_tgt_engine #(.ROW_BITS(ROW_BITS), .DEV_HI(DEV_HI)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .sda_s     (filt[0]),
        .addr_strap(addr_strap),
        .store_busy(store_busy),
        .sda_oe    (sda_oe),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/test_i2c_row_target.sv
`timescale 1ns/1ps
module test_i2c_row_target;

    localparam int H = 10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       busy  = 1'b0;
    logic       sda_oe, wr_req, rd_req;
    logic [7:0] wr_addr, wr_data, rd_addr;
    logic [7:0] rd_data_r;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    i2c_row_target i_i2c_row_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_strap(strap), .store_busy(busy), .sda_oe(sda_oe),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data_r)
    );

    function automatic logic [7:0] init_val(input int i);
        init_val = 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] row_inc(input logic [7:0] a);
        row_inc = {a[7:3], a[2:0] + 3'd1};
    endfunction

    // register store model
    logic [7:0] mem [256];
    int wr_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else begin
            if (wr_req) begin
                mem[wr_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (rd_req) rd_data_r <= mem[rd_addr];
        end
    end

    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;
    logic [7:0] wbuf [16];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b; hw(H); scl_m = 1'b1;
        if (glitch) begin
            hw(H/2); sda_m = 1'b0; hw(1); sda_m = 1'b1; hw(H/2 - 1);
        end else begin
            hw(H);
        end
        scl_m = 1'b0; hw(2);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && b[i]);
        sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H/2);
        ack = sda_line; hw(H/2); scl_m = 1'b0; hw(2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(H); scl_m = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); scl_m = 1'b0; hw(2);
        end
        send_bit(mack ? 1'b0 : 1'b1, 1'b0);
        sda_m = 1'b1;
    endtask

    function automatic int mism();
        int m = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) m++;
        return m;
    endfunction

    function automatic logic [7:0] dev(input bit rd);
        return {6'b110000, strap, rd};
    endfunction

    // write transfer: address byte, location byte, n data bytes
    task automatic do_write(input logic [7:0] dbyte, input logic [7:0] ra, input int n,
                            input bit expect_ack, input bit glitch, input string req);
        logic a;
        logic [7:0] p;
        int w0;
        w0 = wr_cnt;
        p  = ra;
        bus_start();
        send_byte(dbyte, 1'b0, a); chk(req, "address ack", a, expect_ack ? 0 : 1);
        send_byte(ra, 1'b0, a);    chk(req, "location ack", a, expect_ack ? 0 : 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], glitch, a);
            chk(req, "data ack", a, expect_ack ? 0 : 1);
            if (expect_ack) begin
                exp_mem[p] = wbuf[k];
                p = row_inc(p);
            end
        end
        bus_stop();
        hw(4);
        if (expect_ack) exp_ptr = p;
        chk(req, "store write count", wr_cnt - w0, expect_ack ? n : 0);
        chk(req, "store contents mismatches", mism(), 0);
    endtask

    // read transfer, optionally preceded by a location-setting dummy write
    task automatic do_read(input bit set_loc, input logic [7:0] ra, input int n, input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        if (set_loc) begin
            send_byte(dev(1'b0), 1'b0, a); chk(req, "dummy address ack", a, 0);
            send_byte(ra, 1'b0, a);        chk(req, "dummy location ack", a, 0);
            exp_ptr = ra;
            bus_start();
        end
        send_byte(dev(1'b1), 1'b0, a); chk(req, "read address ack", a, 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(req, "read byte", b, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 8'd1;
        end
        hw(10);
        chk("R6", "sda released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        hw(5);
        rst_n = 1'b1;
        hw(3);
        chk("R10", "sda_oe after reset", sda_oe, 0);
        chk("R10", "wr_req after reset", wr_req, 0);
        chk("R10", "rd_req after reset", rd_req, 0);

        // R1 R11: plain write of three bytes
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h0F;
        do_write(dev(1'b0), 8'h20, 3, 1, 0, "R11");

        // R4: burst from offset 6 wraps inside row 40h..47h
        for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'h90 + k);
        do_write(dev(1'b0), 8'h46, 5, 1, 0, "R4");
        chk("R4", "row wrap landed at 41h", mem[8'h41], 8'h93);
        chk("R4", "next row untouched", mem[8'h48], init_val(8'h48));

        // R5: bare read starts at current counter (43h)
        do_read(0, 8'h00, 2, "R5");

        // R3: location byte only, then bare read starts there
        do_write(dev(1'b0), 8'h22, 0, 1, 0, "R3");
        do_read(0, 8'h00, 1, "R3");

        // R5 R6: dummy write then read across FFh
        do_read(1, 8'hFE, 3, "R6");
        chk("R6", "counter wrapped to 01h", exp_ptr, 8'h01);
        do_read(0, 8'h00, 1, "R6");

        // R2: wrong address is ignored and does not move the counter
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        do_write({6'b110000, ~strap, 1'b0}, 8'h60, 2, 0, 0, "R2");
        do_read(0, 8'h00, 1, "R2");

        // R1: strap high selects the other address
        strap = 1'b1;
        wbuf[0] = 8'h77;
        do_write(dev(1'b0), 8'h10, 1, 1, 0, "R1");
        do_read(1, 8'h10, 1, "R1");
        strap = 1'b0;

        // R7: busy store refuses the address
        busy = 1'b1;
        wbuf[0] = 8'hEE;
        do_write(dev(1'b0), 8'h30, 1, 0, 0, "R7");
        busy = 1'b0;
        do_write(dev(1'b0), 8'h30, 1, 1, 0, "R7");

        // R8: repeated START in the middle of a write
        begin
            logic a;
            bus_start();
            send_byte(dev(1'b0), 1'b0, a); chk("R8", "first address ack", a, 0);
            send_byte(8'h50, 1'b0, a);
            send_byte(8'hC3, 1'b0, a);     exp_mem[8'h50] = 8'hC3;
            bus_start();
            send_byte(dev(1'b0), 1'b0, a); chk("R8", "restart address ack", a, 0);
            send_byte(8'h58, 1'b0, a);
            send_byte(8'h3D, 1'b0, a);     exp_mem[8'h58] = 8'h3D;
            bus_stop();
            hw(4);
            exp_ptr = 8'h59;
            chk("R8", "both writes stored", mism(), 0);
            chk("R8", "idle after STOP", sda_oe, 0);
        end

        // R9: one-cycle SDA pulses while SCL high are ignored
        wbuf[0] = 8'hFF; wbuf[1] = 8'hB7;
        do_write(dev(1'b0), 8'h70, 2, 1, 1, "R9");

        // random bursts and reads against the bench model
        for (int it = 0; it < 10; it++) begin
            logic [7:0] ra;
            int n;
            ra = 8'($urandom);
            n  = 1 + int'($urandom % 10);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(dev(1'b0), ra, n, 1, 0, "R4");
            if ($urandom % 2) do_read(0, 8'h00, 1 + int'($urandom % 4), "R5");
            else              do_read(1, 8'($urandom), 1 + int'($urandom % 5), "R6");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule